// File: doc/BRIEF.md
# Bus Transaction Access Monitor

This block stands on a shared bus path between several requesting chiplet masters and the shared slaves behind them. Every transfer a master starts is checked against a small programmable policy before anything reaches a slave. One table of address rules grants read and/or write rights to a given master over a masked address window. A second table names write values that may never land in a protected window. A transfer that no rule grants, or that hits a forbidden-value rule, is stopped at the monitor and answered with a two-cycle bus error. A transfer that passes is re-issued on the slave side with one extra address cycle.

Both tables are loaded through a simple configuration write port. A lock input freezes the tables until the next reset. The first refused transfer leaves a sticky record of its master and address for later inspection.

The master side uses a simplified bus phase. The master presents the transfer type, master number, address, direction and write data in one cycle. The monitor takes that request only while it is idle (`m_hready_o` high and no transfer open). The transfer is finished on the first later cycle in which `m_hready_o` is high again, and `m_hresp_o` in that cycle carries the outcome (0 okay, 1 error).

Top module: `bus_access_monitor`

## Requirements
- R1: An address rule matches a transfer when the rule is valid, its master number equals `m_hmaster_i`, and `(m_haddr_i & mask) == (base & mask)`.
- R2: Among matching address rules the one with the lowest index alone decides the transfer. A transfer that matches no rule is refused (default deny).
- R3: The 2-bit right code of a rule is interpreted as follows: bit 0 grants reads, bit 1 grants writes. So 2'b01 is read only, 2'b10 is write only, 2'b11 is both, and the reserved 2'b00 grants nothing.
- R4: A refused transfer never produces an address cycle on the slave side (`s_htrans_o` stays 2'b00).
- R5: A refused transfer is answered with two cycles. In the first, `m_hready_o`=0 and `m_hresp_o`=1. In the second, `m_hready_o`=1 and `m_hresp_o`=1. The monitor is idle in the next cycle, with `m_hready_o`=1 and `m_hresp_o`=0.
- R6: A granted transfer shows on the slave side in the cycle after acceptance as exactly one address cycle: `s_htrans_o`=2'b10, with the accepted address, direction and master number. `s_hwdata_o` holds the write data. After that, `m_hready_o`, `m_hresp_o` and `m_hrdata_o` follow `s_hready_i`, `s_hresp_i` and `s_hrdata_i` until `s_hready_i` is high.
- R7: A data rule refuses a write when the rule is valid, `(addr & mask) == (base & mask)` and the write data equals the rule's forbidden value. This applies even when the address rules grant the write. Reads are never affected by data rules.
- R8: With `cfg_we_i` high, `cfg_tbl_i`=0 loads address rule `cfg_idx_i` and `cfg_tbl_i`=1 loads data rule `cfg_idx_i`. A pulse on `cfg_lock_i` sets `cfg_locked_o`. It then stays set until reset, and writes presented while it is set change nothing.
- R9: The first refused transfer after reset sets `viol_valid_o` and stores its master number and address in `viol_master_o` and `viol_addr_o`. Later refusals leave all three unchanged.
- R10: After reset, all rules are invalid, the lock and violation record are clear, `m_hready_o`=1, `m_hresp_o`=0 and `s_htrans_o`=2'b00.
- R11: A request is taken only when `m_htrans_i` is 2'b10 or 2'b11 and the monitor is idle. Types 2'b00 and 2'b01 start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_htrans_i | input | 2 | Master transfer type |
| m_hmaster_i | input | ID_W | Requesting master number |
| m_haddr_i | input | ADDR_W | Master address |
| m_hwrite_i | input | 1 | Master direction, 1 = write |
| m_hwdata_i | input | DATA_W | Master write data, same cycle as address |
| m_hready_o | output | 1 | Ready / transfer done to master |
| m_hresp_o | output | 1 | Response to master, 1 = error |
| m_hrdata_o | output | DATA_W | Read data to master |
| s_htrans_o | output | 2 | Slave transfer type |
| s_hmaster_o | output | ID_W | Master number toward slave |
| s_haddr_o | output | ADDR_W | Slave address |
| s_hwrite_o | output | 1 | Slave direction |
| s_hwdata_o | output | DATA_W | Slave write data |
| s_hready_i | input | 1 | Slave ready |
| s_hresp_i | input | 1 | Slave response, 1 = error |
| s_hrdata_i | input | DATA_W | Slave read data |
| cfg_we_i | input | 1 | Rule write strobe |
| cfg_tbl_i | input | 1 | 0 = address rules, 1 = data rules |
| cfg_idx_i | input | CFG_IDX_W | Rule index |
| cfg_valid_i | input | 1 | Rule valid bit |
| cfg_id_i | input | ID_W | Master number of an address rule |
| cfg_base_i | input | ADDR_W | Window base |
| cfg_mask_i | input | ADDR_W | Window mask |
| cfg_perm_i | input | 2 | Right code of an address rule |
| cfg_value_i | input | DATA_W | Forbidden value of a data rule |
| cfg_lock_i | input | 1 | Lock request |
| cfg_locked_o | output | 1 | Tables locked |
| viol_valid_o | output | 1 | A refusal has been recorded |
| viol_master_o | output | ID_W | Master number of first refusal |
| viol_addr_o | output | ADDR_W | Address of first refusal |

## Verification
The bench aims at rule overlap. A narrow read-only rule sits in front of a wider read/write rule for the same master. A write into the narrow window must be refused; a design that let any match grant, or picked the highest index, would accept it. The reserved right code, a master number that matches no rule, and a forbidden value written into an otherwise writable window are all driven. A decoder that treated 2'b00 as full access, or ignored the data rules, would forward these transfers and return okay. A response that collapsed the error into one cycle, or leaked an address cycle to the slave, shows up as a wrong low-ready count or a nonzero forward count. Later refusals, rule writes after the lock, and idle or busy transfer types are all checked at the ports against a record or grant that must not move.

// File: rtl/bam_pkg.sv
package bam_pkg;
  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_BUSY   = 2'b01;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [1:0] TRANS_SEQ    = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FWD_ADDR,
    ST_FWD_DATA,
    ST_ERR_1,
    ST_ERR_2
  } xfer_st_e;
endpackage

// File: rtl/bam_addr_policy.sv
module bam_addr_policy #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int N_ENT  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [ID_W-1:0]   wr_id_i,
  input  logic [ADDR_W-1:0] wr_base_i,
  input  logic [ADDR_W-1:0] wr_mask_i,
  input  logic [1:0]        wr_perm_i,
  input  logic [ID_W-1:0]   chk_id_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  logic              chk_write_i,
  output logic              allow_o
);
  logic [N_ENT-1:0]             vld_q;
  logic [N_ENT-1:0][ID_W-1:0]   id_q;
  logic [N_ENT-1:0][ADDR_W-1:0] base_q;
  logic [N_ENT-1:0][ADDR_W-1:0] mask_q;
  logic [N_ENT-1:0][1:0]        perm_q;
  logic [N_ENT-1:0]             match;
  logic                         hit;
  logic [1:0]                   sel_perm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      id_q   <= '0;
      base_q <= '0;
      mask_q <= '0;
      perm_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (wr_idx_i == IDX_W'(i)) begin
          vld_q[i]  <= wr_valid_i;
          id_q[i]   <= wr_id_i;
          base_q[i] <= wr_base_i;
          mask_q[i] <= wr_mask_i;
          perm_q[i] <= wr_perm_i;
        end
      end
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_match
    assign match[g] = vld_q[g] && (id_q[g] == chk_id_i) &&
                      (((chk_addr_i ^ base_q[g]) & mask_q[g]) == '0);
  end

  // lowest index wins: scan downward so the last hit kept is the lowest
  always_comb begin
    hit      = 1'b0;
    sel_perm = 2'b00;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit      = 1'b1;
        sel_perm = perm_q[i];
      end
    end
  end

  assign allow_o = hit && (chk_write_i ? sel_perm[1] : sel_perm[0]);

  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == '0) |=> (vld_q[0] == $past(wr_valid_i))); // R8
endmodule

// File: rtl/bam_data_guard.sv
module bam_data_guard #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int N_ENT  = 2,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_base_i,
  input  logic [ADDR_W-1:0] wr_mask_i,
  input  logic [DATA_W-1:0] wr_value_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  logic              chk_write_i,
  input  logic [DATA_W-1:0] chk_wdata_i,
  output logic              block_o
);
  logic [N_ENT-1:0]             vld_q;
  logic [N_ENT-1:0][ADDR_W-1:0] base_q;
  logic [N_ENT-1:0][ADDR_W-1:0] mask_q;
  logic [N_ENT-1:0][DATA_W-1:0] val_q;
  logic [N_ENT-1:0]             hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
      val_q  <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (wr_idx_i == IDX_W'(i)) begin
          vld_q[i]  <= wr_valid_i;
          base_q[i] <= wr_base_i;
          mask_q[i] <= wr_mask_i;
          val_q[i]  <= wr_value_i;
        end
      end
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_hit
    assign hit[g] = vld_q[g] && (chk_wdata_i == val_q[g]) &&
                    (((chk_addr_i ^ base_q[g]) & mask_q[g]) == '0);
  end

  assign block_o = chk_write_i && (|hit);
endmodule

// File: rtl/bam_xfer_ctrl.sv
module bam_xfer_ctrl import bam_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              grant_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              accept_o,
  output logic              hready_o,
  output logic              hresp_o,
  output logic [DATA_W-1:0] hrdata_o,
  output logic [1:0]        s_htrans_o,
  output logic [ID_W-1:0]   s_hmaster_o,
  output logic [ADDR_W-1:0] s_haddr_o,
  output logic              s_hwrite_o,
  output logic [DATA_W-1:0] s_hwdata_o,
  input  logic              s_hready_i,
  input  logic              s_hresp_i,
  input  logic [DATA_W-1:0] s_hrdata_i
);
  xfer_st_e          st_q, st_d;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;

  assign accept_o = (st_q == ST_IDLE) && req_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (req_i) st_d = grant_i ? ST_FWD_ADDR : ST_ERR_1;
      ST_FWD_ADDR: st_d = ST_FWD_DATA;
      ST_FWD_DATA: if (s_hready_i) st_d = ST_IDLE;
      ST_ERR_1:    st_d = ST_ERR_2;
      ST_ERR_2:    st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      id_q    <= '0;
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept_o) begin
        id_q    <= id_i;
        addr_q  <= addr_i;
        write_q <= write_i;
        wdata_q <= wdata_i;
      end
    end
  end

  always_comb begin
    hready_o = 1'b0;
    hresp_o  = 1'b0;
    hrdata_o = '0;
    unique case (st_q)
      ST_IDLE:     hready_o = 1'b1;
      ST_FWD_DATA: begin
        hready_o = s_hready_i;
        hresp_o  = s_hresp_i;
        hrdata_o = s_hrdata_i;
      end
      ST_ERR_1:    hresp_o = 1'b1;
      ST_ERR_2:    begin
        hready_o = 1'b1;
        hresp_o  = 1'b1;
      end
      default:     hready_o = 1'b0;
    endcase
  end

  assign s_htrans_o  = (st_q == ST_FWD_ADDR) ? TRANS_NONSEQ : TRANS_IDLE;
  assign s_hmaster_o = id_q;
  assign s_haddr_o   = addr_q;
  assign s_hwrite_o  = write_q;
  assign s_hwdata_o  = wdata_q;

  AST_DENY_NO_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !grant_i) |=> (s_htrans_o == TRANS_IDLE)); // R4
  AST_ERR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !grant_i) |=> (!hready_o && hresp_o)); // R5
  AST_ERR_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ERR_1) |=> (hready_o && hresp_o)); // R5
  AST_FWD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && grant_i) |=> (s_htrans_o == TRANS_NONSEQ && s_haddr_o == $past(addr_i))); // R6
endmodule

// File: rtl/bus_access_monitor.sv
module bus_access_monitor import bam_pkg::*; #(
  parameter int  ADDR_W     = 32,
  parameter int  DATA_W     = 32,
  parameter int  ID_W       = 4,
  parameter int  N_ADDR_ENT = 4,
  parameter int  N_DATA_ENT = 2,
  localparam int N_MAX      = (N_ADDR_ENT > N_DATA_ENT) ? N_ADDR_ENT : N_DATA_ENT,
  localparam int CFG_IDX_W  = (N_MAX > 1) ? $clog2(N_MAX) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           m_htrans_i,
  input  logic [ID_W-1:0]      m_hmaster_i,
  input  logic [ADDR_W-1:0]    m_haddr_i,
  input  logic                 m_hwrite_i,
  input  logic [DATA_W-1:0]    m_hwdata_i,
  output logic                 m_hready_o,
  output logic                 m_hresp_o,
  output logic [DATA_W-1:0]    m_hrdata_o,
  output logic [1:0]           s_htrans_o,
  output logic [ID_W-1:0]      s_hmaster_o,
  output logic [ADDR_W-1:0]    s_haddr_o,
  output logic                 s_hwrite_o,
  output logic [DATA_W-1:0]    s_hwdata_o,
  input  logic                 s_hready_i,
  input  logic                 s_hresp_i,
  input  logic [DATA_W-1:0]    s_hrdata_i,
  input  logic                 cfg_we_i,
  input  logic                 cfg_tbl_i,
  input  logic [CFG_IDX_W-1:0] cfg_idx_i,
  input  logic                 cfg_valid_i,
  input  logic [ID_W-1:0]      cfg_id_i,
  input  logic [ADDR_W-1:0]    cfg_base_i,
  input  logic [ADDR_W-1:0]    cfg_mask_i,
  input  logic [1:0]           cfg_perm_i,
  input  logic [DATA_W-1:0]    cfg_value_i,
  input  logic                 cfg_lock_i,
  output logic                 cfg_locked_o,
  output logic                 viol_valid_o,
  output logic [ID_W-1:0]      viol_master_o,
  output logic [ADDR_W-1:0]    viol_addr_o
);
  logic              lock_q;
  logic              wr_addr_tbl, wr_data_tbl;
  logic              req, addr_ok, data_blk, grant, accept;
  logic              viol_q;
  logic [ID_W-1:0]   viol_id_q;
  logic [ADDR_W-1:0] viol_addr_q;

  assign wr_addr_tbl = cfg_we_i && !lock_q && !cfg_tbl_i;
  assign wr_data_tbl = cfg_we_i && !lock_q &&  cfg_tbl_i;
  assign req   = (m_htrans_i == TRANS_NONSEQ) || (m_htrans_i == TRANS_SEQ);
  assign grant = addr_ok && !data_blk;

  bam_addr_policy #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .N_ENT(N_ADDR_ENT), .IDX_W(CFG_IDX_W)
  ) u_addr_policy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_addr_tbl),
    .wr_idx_i    (cfg_idx_i),
    .wr_valid_i  (cfg_valid_i),
    .wr_id_i     (cfg_id_i),
    .wr_base_i   (cfg_base_i),
    .wr_mask_i   (cfg_mask_i),
    .wr_perm_i   (cfg_perm_i),
    .chk_id_i    (m_hmaster_i),
    .chk_addr_i  (m_haddr_i),
    .chk_write_i (m_hwrite_i),
    .allow_o     (addr_ok)
  );

  bam_data_guard #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_ENT(N_DATA_ENT), .IDX_W(CFG_IDX_W)
  ) u_data_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_data_tbl),
    .wr_idx_i    (cfg_idx_i),
    .wr_valid_i  (cfg_valid_i),
    .wr_base_i   (cfg_base_i),
    .wr_mask_i   (cfg_mask_i),
    .wr_value_i  (cfg_value_i),
    .chk_addr_i  (m_haddr_i),
    .chk_write_i (m_hwrite_i),
    .chk_wdata_i (m_hwdata_i),
    .block_o     (data_blk)
  );

  bam_xfer_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
  ) u_xfer_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .grant_i     (grant),
    .id_i        (m_hmaster_i),
    .addr_i      (m_haddr_i),
    .write_i     (m_hwrite_i),
    .wdata_i     (m_hwdata_i),
    .accept_o    (accept),
    .hready_o    (m_hready_o),
    .hresp_o     (m_hresp_o),
    .hrdata_o    (m_hrdata_o),
    .s_htrans_o  (s_htrans_o),
    .s_hmaster_o (s_hmaster_o),
    .s_haddr_o   (s_haddr_o),
    .s_hwrite_o  (s_hwrite_o),
    .s_hwdata_o  (s_hwdata_o),
    .s_hready_i  (s_hready_i),
    .s_hresp_i   (s_hresp_i),
    .s_hrdata_i  (s_hrdata_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q      <= 1'b0;
      viol_q      <= 1'b0;
      viol_id_q   <= '0;
      viol_addr_q <= '0;
    end else begin
      if (cfg_lock_i) lock_q <= 1'b1;
      if (accept && !grant && !viol_q) begin
        viol_q      <= 1'b1;
        viol_id_q   <= m_hmaster_i;
        viol_addr_q <= m_haddr_i;
      end
    end
  end

  assign cfg_locked_o  = lock_q;
  assign viol_valid_o  = viol_q;
  assign viol_master_o = viol_id_q;
  assign viol_addr_o   = viol_addr_q;

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_locked_o |=> cfg_locked_o); // R8
  AST_VIOL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_valid_o |=> (viol_valid_o && $stable(viol_addr_o) && $stable(viol_master_o))); // R9
  AST_IDLE_TYPES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_hready_o && !m_hresp_o && !req) |=> (s_htrans_o == TRANS_IDLE)); // R11
endmodule

// File: tb/bus_access_monitor_test.sv
module bus_access_monitor_test;
  localparam int AW = 32, DW = 32, IW = 4, NA = 4, ND = 2, CIW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] m_htrans = 2'b00;
  logic [IW-1:0] m_hmaster = '0;
  logic [AW-1:0] m_haddr = '0;
  logic m_hwrite = 1'b0;
  logic [DW-1:0] m_hwdata = '0;
  logic m_hready, m_hresp;
  logic [DW-1:0] m_hrdata;
  logic [1:0] s_htrans;
  logic [IW-1:0] s_hmaster;
  logic [AW-1:0] s_haddr;
  logic s_hwrite;
  logic [DW-1:0] s_hwdata;
  logic s_hready = 1'b1, s_hresp = 1'b0;
  logic [DW-1:0] s_hrdata = '0;
  logic cfg_we = 1'b0, cfg_tbl = 1'b0, cfg_valid = 1'b0, cfg_lock = 1'b0;
  logic [CIW-1:0] cfg_idx = '0;
  logic [IW-1:0] cfg_id = '0;
  logic [AW-1:0] cfg_base = '0, cfg_mask = '0;
  logic [1:0] cfg_perm = '0;
  logic [DW-1:0] cfg_value = '0;
  logic cfg_locked, viol_valid;
  logic [IW-1:0] viol_master;
  logic [AW-1:0] viol_addr;

  bus_access_monitor #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW),
                       .N_ADDR_ENT(NA), .N_DATA_ENT(ND)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .m_htrans_i(m_htrans), .m_hmaster_i(m_hmaster), .m_haddr_i(m_haddr),
    .m_hwrite_i(m_hwrite), .m_hwdata_i(m_hwdata),
    .m_hready_o(m_hready), .m_hresp_o(m_hresp), .m_hrdata_o(m_hrdata),
    .s_htrans_o(s_htrans), .s_hmaster_o(s_hmaster), .s_haddr_o(s_haddr),
    .s_hwrite_o(s_hwrite), .s_hwdata_o(s_hwdata),
    .s_hready_i(s_hready), .s_hresp_i(s_hresp), .s_hrdata_i(s_hrdata),
    .cfg_we_i(cfg_we), .cfg_tbl_i(cfg_tbl), .cfg_idx_i(cfg_idx),
    .cfg_valid_i(cfg_valid), .cfg_id_i(cfg_id), .cfg_base_i(cfg_base),
    .cfg_mask_i(cfg_mask), .cfg_perm_i(cfg_perm), .cfg_value_i(cfg_value),
    .cfg_lock_i(cfg_lock), .cfg_locked_o(cfg_locked),
    .viol_valid_o(viol_valid), .viol_master_o(viol_master), .viol_addr_o(viol_addr)
  );

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  int n_chk = 0, n_fail = 0;

  // bench-side rule model
  bit            am_v[NA];
  logic [IW-1:0] am_id[NA];
  logic [AW-1:0] am_base[NA], am_mask[NA];
  logic [1:0]    am_perm[NA];
  bit            dm_v[ND];
  logic [AW-1:0] dm_base[ND], dm_mask[ND];
  logic [DW-1:0] dm_val[ND];
  bit            lock_m = 1'b0;
  bit            v_exp = 1'b0;
  logic [IW-1:0] v_id = '0;
  logic [AW-1:0] v_addr = '0;

  function automatic logic [DW-1:0] rd_fn(logic [AW-1:0] a);
    return a ^ 32'h5A3C_0F96;
  endfunction

  function automatic bit exp_grant(logic [IW-1:0] id, logic [AW-1:0] a, bit wr,
                                   logic [DW-1:0] wd);
    bit found = 1'b0;
    bit ok = 1'b0;
    for (int i = 0; i < NA; i++) begin
      if (!found && am_v[i] && am_id[i] == id && ((a & am_mask[i]) == (am_base[i] & am_mask[i]))) begin
        found = 1'b1;
        ok = wr ? am_perm[i][1] : am_perm[i][0];
      end
    end
    if (wr) begin
      for (int j = 0; j < ND; j++)
        if (dm_v[j] && ((a & dm_mask[j]) == (dm_base[j] & dm_mask[j])) && wd == dm_val[j])
          ok = 1'b0;
    end
    return ok;
  endfunction

  task automatic chk(bit c, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_addr(int idx, bit v, logic [IW-1:0] id, logic [AW-1:0] b,
                          logic [AW-1:0] m, logic [1:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tbl = 1'b0; cfg_idx = CIW'(idx); cfg_valid = v;
    cfg_id = id; cfg_base = b; cfg_mask = m; cfg_perm = p;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!lock_m) begin
      am_v[idx] = v; am_id[idx] = id; am_base[idx] = b; am_mask[idx] = m; am_perm[idx] = p;
    end
  endtask

  task automatic cfg_data(int idx, bit v, logic [AW-1:0] b, logic [AW-1:0] m,
                          logic [DW-1:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tbl = 1'b1; cfg_idx = CIW'(idx); cfg_valid = v;
    cfg_base = b; cfg_mask = m; cfg_value = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!lock_m) begin
      dm_v[idx] = v; dm_base[idx] = b; dm_mask[idx] = m; dm_val[idx] = val;
    end
  endtask

  task automatic xfer(logic [IW-1:0] id, logic [AW-1:0] a, bit wr, logic [DW-1:0] wd,
                      string tag);
    bit g = exp_grant(id, a, wr, wd);
    int fwd = 0;
    int low = 0;
    bit err_low_ok = 1'b1;
    bit fin = 1'b0;
    logic resp = 1'b0;
    logic [DW-1:0] rd = '0, wseen = '0;
    @(negedge clk);
    m_htrans = 2'b10; m_hmaster = id; m_haddr = a; m_hwrite = wr; m_hwdata = wd;
    s_hready = 1'b1;
    @(negedge clk);
    m_htrans = 2'b00;
    for (int c = 0; c < 64 && !fin; c++) begin
      s_hready = ($urandom % 4) != 0;
      #1;
      if (s_htrans == 2'b10) begin
        fwd++;
        chk(s_haddr == a, "R6", "slave addr", s_haddr, a);
        chk(s_hwrite == wr && s_hmaster == id, "R6", "slave dir/id",
            {s_hmaster, 3'b0, s_hwrite}, {id, 3'b0, wr});
        s_hrdata = rd_fn(s_haddr);
      end
      if (m_hready) begin
        fin = 1'b1; resp = m_hresp; rd = m_hrdata; wseen = s_hwdata;
      end else begin
        low++;
        if (!g && !m_hresp) err_low_ok = 1'b0;
        @(negedge clk);
      end
    end
    chk(fin, "R11", "transfer completes", 32'(fin), 1);
    chk(resp == !g, tag, "grant outcome (resp)", 32'(resp), 32'(!g));
    if (g) begin
      chk(fwd == 1, "R6", "forwarded address cycles", fwd, 1);
      if (wr) chk(wseen == wd, "R6", "slave write data", wseen, wd);
      else    chk(rd == rd_fn(a), "R6", "read data", rd, rd_fn(a));
    end else begin
      chk(fwd == 0, "R4", "forwarded cycles on refusal", fwd, 0);
      chk(low == 1 && err_low_ok, "R5", "error first cycle", low, 1);
      @(negedge clk); #1;
      chk(m_hready && !m_hresp, "R5", "idle after error", {m_hready, m_hresp}, 2'b10);
      if (!v_exp) begin v_exp = 1'b1; v_id = id; v_addr = a; end
    end
    chk(viol_valid == v_exp && viol_master == v_id && viol_addr == v_addr, "R9",
        "violation record", viol_addr, v_addr);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog act=hung exp=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NA; i++) begin am_v[i] = 0; am_id[i] = '0; am_base[i] = '0; am_mask[i] = '0; am_perm[i] = '0; end
    for (int j = 0; j < ND; j++) begin dm_v[j] = 0; dm_base[j] = '0; dm_mask[j] = '0; dm_val[j] = '0; end
    repeat (3) @(negedge clk);
    #1;
    chk(m_hready && !m_hresp, "R10", "master side in reset", {m_hready, m_hresp}, 2'b10);
    chk(s_htrans == 2'b00, "R10", "slave idle in reset", s_htrans, 0);
    chk(!cfg_locked && !viol_valid, "R10", "lock/viol clear", {cfg_locked, viol_valid}, 0);
    @(negedge clk); rst_n = 1'b1;

    // empty tables: default deny (R10, R2)
    xfer(4'd1, 32'h1000_0010, 1'b0, '0, "R10");

    cfg_addr(0, 1, 4'd1, 32'h1000_0000, 32'hFFFF_F000, 2'b01);
    cfg_addr(1, 1, 4'd1, 32'h1000_0000, 32'hF000_0000, 2'b11);
    cfg_addr(2, 1, 4'd2, 32'h2000_0000, 32'hF000_0000, 2'b10);
    cfg_addr(3, 1, 4'd3, 32'h3000_0000, 32'hF000_0000, 2'b00);
    cfg_data(0, 1, 32'h1000_8000, 32'hFFFF_F000, 32'hDEAD_BEEF);
    cfg_data(1, 1, 32'h2000_0000, 32'hFFFF_0000, 32'h0000_0000);

    xfer(4'd1, 32'h1000_0020, 1'b0, '0, "R2");            // narrow read-only rule grants read
    xfer(4'd1, 32'h1000_0020, 1'b1, 32'h1, "R2");         // lower index decides: write refused
    xfer(4'd1, 32'h1000_5000, 1'b1, 32'h1, "R1");         // wide rule grants write
    xfer(4'd2, 32'h1000_5000, 1'b0, '0, "R1");            // master number mismatch
    xfer(4'd2, 32'h2004_0000, 1'b1, 32'h5, "R3");         // write only: write ok
    xfer(4'd2, 32'h2004_0000, 1'b0, '0, "R3");            // write only: read refused
    xfer(4'd3, 32'h3000_0000, 1'b0, '0, "R3");            // reserved code grants nothing
    xfer(4'd3, 32'h3000_0000, 1'b1, 32'h7, "R3");
    xfer(4'd1, 32'h1000_8004, 1'b1, 32'hDEAD_BEEF, "R7"); // forbidden value
    xfer(4'd1, 32'h1000_8004, 1'b1, 32'hDEAD_BEEE, "R7");
    xfer(4'd1, 32'h1000_8004, 1'b0, '0, "R7");            // reads unaffected
    xfer(4'd2, 32'h2000_0100, 1'b1, 32'h0, "R7");

    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] wd;
      logic [3:0] mid_n;
      int sel = $urandom % 3;
      mid_n = (sel == 0) ? 4'h0 : (sel == 1) ? 4'h5 : 4'h8;
      a = {4'(($urandom % 4)), 12'h000, mid_n, 12'(($urandom % 4096) & 32'hFFC)};
      sel = $urandom % 4;
      wd = (sel == 0) ? 32'hDEAD_BEEF : (sel == 1) ? 32'h0 : $urandom;
      xfer(4'(($urandom % 4)), a, 1'($urandom % 2), wd, "R1");
    end

    // idle and busy types start nothing (R11)
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      m_htrans = (k % 2 == 0) ? 2'b00 : 2'b01;
      m_hmaster = 4'd1; m_haddr = 32'h1000_5000; m_hwrite = 1'b0;
      @(negedge clk); #1;
      chk(s_htrans == 2'b00 && m_hready && !m_hresp, "R11", "no transfer from idle/busy",
          {s_htrans, m_hready, m_hresp}, 4'b0010);
    end
    m_htrans = 2'b00;

    // lock (R8)
    @(negedge clk); cfg_lock = 1'b1;
    @(negedge clk); cfg_lock = 1'b0; lock_m = 1'b1;
    #1;
    chk(cfg_locked, "R8", "lock set", 32'(cfg_locked), 1);
    cfg_addr(3, 1, 4'd3, 32'h3000_0000, 32'hF000_0000, 2'b11);
    cfg_data(0, 0, 32'h0, 32'h0, 32'h0);
    xfer(4'd3, 32'h3000_0040, 1'b0, '0, "R8");            // still refused
    xfer(4'd1, 32'h1000_8008, 1'b1, 32'hDEAD_BEEF, "R8"); // data rule still active
    repeat (5) @(negedge clk);
    #1;
    chk(cfg_locked, "R8", "lock stays set", 32'(cfg_locked), 1);

    summary();
  end
endmodule